// File: doc/BRIEF.md
# Processor Status Resolver and Data-Memory Access Gate

This block sits beside the execute and memory stages of a simple sequential processor. Each cycle it takes a handful of fault and request flags and reduces them to one status code. From the fetch side it sees an instruction-memory fault, an undecodable opcode and a halt opcode. From the memory side it sees the load and store requests and the memory's verdict on whether the current data address is legal. It also turns the raw load and store requests into qualified enables, so that no memory access is made for an instruction that has already faulted.

A store probes its address before it commits. An illegal store address is reported as an address fault, and the write strobe never reaches the memory. A load that is not performed, or that hits an illegal address, tells the datapath to use zero as the loaded value. The status is reported in two ways. One output is combinational and belongs to the current cycle. The other is registered and holds the status of the instruction that has just retired.

Top module: `pstat_gate_top`

## Requirements
- R1: While reset is high and after it is released, the retired status output reads OK (code 0) until the first non-reset cycle has been registered.
- R2: Status codes are OK=0, HLT=1, ADR=2, INS=3. When several faults are present, ADR wins over INS, INS wins over HLT, and HLT wins over OK.
- R3: An instruction-memory fault gives ADR in that cycle, whatever the other inputs are.
- R4: A halt opcode gives HLT only when there is no instruction-memory fault, no undecodable opcode and no data-memory fault.
- R5: The read enable is high only when a load is requested and the fetch side is clean, meaning no instruction-memory fault, no undecodable opcode and no halt opcode.
- R6: A performed load to an illegal address raises the data-error flag and gives ADR.
- R7: A store requested with a clean fetch side and an illegal address raises the data-error flag, gives ADR and keeps the write enable low.
- R8: The write enable is high exactly when a store is requested and the current status is OK.
- R9: The zero-load select is high whenever no load is performed or the loaded address is illegal.
- R10: When the fetch side is faulty, an illegal data address is ignored. It raises no data-error flag, so an undecodable opcode still reports INS.
- R11: The retired status output equals the current-cycle status of the previous non-reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_err_i | input | 1 | Instruction fetch hit an illegal address |
| bad_op_i | input | 1 | Fetched opcode is not decodable |
| halt_op_i | input | 1 | Fetched opcode is the halt opcode |
| rd_req_i | input | 1 | Instruction requests a data load |
| wr_req_i | input | 1 | Instruction requests a data store |
| addr_ok_i | input | 1 | Data memory reports the current address as legal |
| rd_en_o | output | 1 | Qualified load enable |
| wr_en_o | output | 1 | Qualified store enable |
| rdata_zero_o | output | 1 | Use zero as the loaded value |
| dmem_err_o | output | 1 | Data-side fault in this cycle |
| stat_now_o | output | 2 | Status of the current cycle |
| stat_ret_o | output | 2 | Registered status of the last retired cycle |

## Verification
The hardest cases to reach are those where two faults from different sides arrive in the same cycle. Examples are an undecodable opcode together with a store to an illegal address, and a halt opcode together with a failed load. In these cases the status depends on both the priority order and the rule that data-side probing is suppressed. The directed tasks build each of these combinations on purpose. In the same cycle they check the status, the enables and the zero-load select. On the following clock they check the retired status, so that no single fault path can hide another.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

    typedef enum logic [1:0] {
        ST_OK  = 2'd0,
        ST_HLT = 2'd1,
        ST_ADR = 2'd2,
        ST_INS = 2'd3
    } pstat_e;

    typedef struct packed {
        logic imem_err;
        logic bad_op;
        logic halt_op;
    } fetch_flags_t;

    typedef struct packed {
        logic rd_req;
        logic wr_req;
        logic addr_ok;
    } mem_req_t;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic rdata_zero;
        logic dmem_err;
    } mem_gate_t;

    function automatic logic fetch_is_clean(input fetch_flags_t f);
        return !(f.imem_err || f.bad_op || f.halt_op);
    endfunction

    function automatic pstat_e rank_status(input logic adr, input logic ins,
                                           input logic hlt);
        pstat_e s;
        if (adr)      s = ST_ADR;
        else if (ins) s = ST_INS;
        else if (hlt) s = ST_HLT;
        else          s = ST_OK;
        return s;
    endfunction

endpackage

// File: rtl/pstat_fetch_screen.sv
module pstat_fetch_screen
    import pstat_pkg::*;
(
    input  fetch_flags_t fetch_i,
    output logic         clean_o,
    output logic         fetch_adr_o,
    output logic         fetch_ins_o,
    output logic         fetch_hlt_o
);
    always_comb begin
        clean_o     = fetch_is_clean(fetch_i);
        fetch_adr_o = fetch_i.imem_err;
        fetch_ins_o = fetch_i.bad_op;
        fetch_hlt_o = fetch_i.halt_op;
    end
endmodule

// File: rtl/pstat_dmem_gate.sv
module pstat_dmem_gate
    import pstat_pkg::*;
(
    input  logic      clean_i,
    input  mem_req_t  req_i,
    output mem_gate_t gate_o
);
    logic load_go;
    logic store_probe;

    always_comb begin
        load_go     = req_i.rd_req && clean_i;
        store_probe = req_i.wr_req && clean_i;
        gate_o.rd_en      = load_go;
        gate_o.dmem_err   = (load_go || store_probe) && !req_i.addr_ok;
        gate_o.wr_en      = store_probe && req_i.addr_ok;
        gate_o.rdata_zero = !(load_go && req_i.addr_ok);
    end
endmodule

// File: rtl/pstat_resolve.sv
module pstat_resolve
    import pstat_pkg::*;
(
    input  logic   fetch_adr_i,
    input  logic   fetch_ins_i,
    input  logic   fetch_hlt_i,
    input  logic   dmem_err_i,
    output pstat_e stat_o
);
    always_comb begin
        stat_o = rank_status(fetch_adr_i || dmem_err_i, fetch_ins_i, fetch_hlt_i);
    end
endmodule

// File: rtl/pstat_gate_top.sv
module pstat_gate_top
    import pstat_pkg::*;
#(
    parameter bit RET_REGISTERED = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       imem_err_i,
    input  logic       bad_op_i,
    input  logic       halt_op_i,
    input  logic       rd_req_i,
    input  logic       wr_req_i,
    input  logic       addr_ok_i,
    output logic       rd_en_o,
    output logic       wr_en_o,
    output logic       rdata_zero_o,
    output logic       dmem_err_o,
    output logic [1:0] stat_now_o,
    output logic [1:0] stat_ret_o
);
    fetch_flags_t fetch;
    mem_req_t     mreq;
    mem_gate_t    gate;
    logic         clean, f_adr, f_ins, f_hlt;
    pstat_e       stat_now;

    assign fetch = '{imem_err: imem_err_i, bad_op: bad_op_i, halt_op: halt_op_i};
    assign mreq  = '{rd_req: rd_req_i, wr_req: wr_req_i, addr_ok: addr_ok_i};

    pstat_fetch_screen u_screen (
        .fetch_i     (fetch),
        .clean_o     (clean),
        .fetch_adr_o (f_adr),
        .fetch_ins_o (f_ins),
        .fetch_hlt_o (f_hlt)
    );

    pstat_dmem_gate u_gate (
        .clean_i (clean),
        .req_i   (mreq),
        .gate_o  (gate)
    );

    pstat_resolve u_resolve (
        .fetch_adr_i (f_adr),
        .fetch_ins_i (f_ins),
        .fetch_hlt_i (f_hlt),
        .dmem_err_i  (gate.dmem_err),
        .stat_o      (stat_now)
    );

    assign rd_en_o      = gate.rd_en;
    assign wr_en_o      = gate.wr_en;
    assign rdata_zero_o = gate.rdata_zero;
    assign dmem_err_o   = gate.dmem_err;
    assign stat_now_o   = stat_now;

    generate
        if (RET_REGISTERED) begin : g_ret_reg
            pstat_e ret_q;
            always_ff @(posedge clk) begin
                if (rst) ret_q <= ST_OK;
                else     ret_q <= stat_now;
            end
            assign stat_ret_o = ret_q;
        end else begin : g_ret_pass
            assign stat_ret_o = stat_now;
        end
    endgenerate
endmodule

// File: rtl/pstat_gate_chk.sv
module pstat_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       imem_err_i,
    input logic       bad_op_i,
    input logic       halt_op_i,
    input logic       rd_req_i,
    input logic       wr_req_i,
    input logic       addr_ok_i,
    input logic       rd_en_o,
    input logic       wr_en_o,
    input logic       rdata_zero_o,
    input logic       dmem_err_o,
    input logic [1:0] stat_now_o,
    input logic [1:0] stat_ret_o
);
    AST_IMEM_GIVES_ADR: assert property (@(posedge clk) disable iff (rst)
        imem_err_i |-> stat_now_o == 2'd2); // R3
    AST_READ_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> (rd_req_i && !imem_err_i && !bad_op_i && !halt_op_i)); // R5
    AST_WRITE_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (stat_now_o == 2'd0 && wr_req_i)); // R8
    AST_NO_WRITE_BAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        !addr_ok_i |-> !wr_en_o); // R7
    AST_ZERO_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_en_o |-> rdata_zero_o); // R9
    AST_DERR_IS_ADR: assert property (@(posedge clk) disable iff (rst)
        dmem_err_o |-> stat_now_o == 2'd2); // R6
    AST_RETIRE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stat_ret_o == $past(stat_now_o)); // R11
endmodule

bind pstat_gate_top pstat_gate_chk u_chk (
    .clk(clk), .rst(rst), .imem_err_i(imem_err_i), .bad_op_i(bad_op_i),
    .halt_op_i(halt_op_i), .rd_req_i(rd_req_i), .wr_req_i(wr_req_i),
    .addr_ok_i(addr_ok_i), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o),
    .rdata_zero_o(rdata_zero_o), .dmem_err_o(dmem_err_o),
    .stat_now_o(stat_now_o), .stat_ret_o(stat_ret_o)
);

// File: tb/pstat_gate_top_tb_top.sv
module pstat_gate_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic imem_err_i = 0, bad_op_i = 0, halt_op_i = 0;
    logic rd_req_i = 0, wr_req_i = 0, addr_ok_i = 1;
    logic rd_en_o, wr_en_o, rdata_zero_o, dmem_err_o;
    logic [1:0] stat_now_o, stat_ret_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pstat_gate_top dut_i (
        .clk(clk), .rst(rst), .imem_err_i(imem_err_i), .bad_op_i(bad_op_i),
        .halt_op_i(halt_op_i), .rd_req_i(rd_req_i), .wr_req_i(wr_req_i),
        .addr_ok_i(addr_ok_i), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o),
        .rdata_zero_o(rdata_zero_o), .dmem_err_o(dmem_err_o),
        .stat_now_o(stat_now_o), .stat_ret_o(stat_ret_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic im, input logic bo, input logic ho,
                         input logic rr, input logic wr, input logic ao);
        @(negedge clk);
        imem_err_i = im; bad_op_i = bo; halt_op_i = ho;
        rd_req_i = rr; wr_req_i = wr; addr_ok_i = ao;
        #1;
    endtask

    task automatic expect_now(input string req, input int st, input int rd,
                              input int wr, input int z, input int de);
        chk({req, " status"}, int'(stat_now_o), st);
        chk({req, " rd_en"}, int'(rd_en_o), rd);
        chk({req, " wr_en"}, int'(wr_en_o), wr);
        chk({req, " rdata_zero"}, int'(rdata_zero_o), z);
        chk({req, " dmem_err"}, int'(dmem_err_o), de);
    endtask

    task automatic expect_ret(input string req, input int st);
        @(posedge clk);
        #1;
        chk({req, " retired"}, int'(stat_ret_o), st);
    endtask

    task automatic t_reset();
        drive(1, 1, 1, 0, 0, 0);
        @(posedge clk); #1;
        chk("R1 reset retired", int'(stat_ret_o), 0);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 1);
        chk("R1 first cycle retired", int'(stat_ret_o), 0);
    endtask

    task automatic t_clean_traffic();
        drive(0, 0, 0, 0, 0, 1); expect_now("R9 idle", 0, 0, 0, 1, 0);
        drive(0, 0, 0, 1, 0, 1); expect_now("R5 good load", 0, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 1); expect_now("R8 good store", 0, 0, 1, 1, 0);
        expect_ret("R11 store", 0);
    endtask

    task automatic t_fetch_faults();
        drive(1, 0, 0, 1, 0, 1); expect_now("R3 imem load", 2, 0, 0, 1, 0);
        expect_ret("R11 imem", 2);
        drive(0, 1, 0, 0, 1, 1); expect_now("R2 bad op store", 3, 0, 0, 1, 0);
        expect_ret("R11 bad op", 3);
        drive(0, 0, 1, 1, 0, 1); expect_now("R4 halt", 1, 0, 0, 1, 0);
        expect_ret("R11 halt", 1);
        drive(1, 1, 1, 0, 0, 1); expect_now("R2 all fetch faults", 2, 0, 0, 1, 0);
        drive(0, 1, 1, 0, 0, 1); expect_now("R2 ins over hlt", 3, 0, 0, 1, 0);
    endtask

    task automatic t_data_faults();
        drive(0, 0, 0, 1, 0, 0); expect_now("R6 bad load", 2, 1, 0, 1, 1);
        expect_ret("R11 bad load", 2);
        drive(0, 0, 0, 0, 1, 0); expect_now("R7 bad store", 2, 0, 0, 1, 1);
        drive(0, 0, 0, 0, 0, 0); expect_now("R9 idle bad addr", 0, 0, 0, 1, 0);
    endtask

    task automatic t_mixed();
        drive(0, 1, 0, 0, 1, 0); expect_now("R10 bad op bad store", 3, 0, 0, 1, 0);
        drive(0, 0, 1, 1, 0, 0); expect_now("R10 halt bad load", 1, 0, 0, 1, 0);
        drive(1, 0, 0, 0, 1, 0); expect_now("R3 imem bad store", 2, 0, 0, 1, 0);
        drive(0, 0, 0, 1, 1, 1); expect_now("R8 load and store", 0, 1, 1, 0, 0);
        drive(0, 0, 0, 1, 1, 0); expect_now("R7 load and store bad", 2, 1, 0, 1, 1);
        expect_ret("R11 mixed", 2);
    endtask

    initial begin
        t_reset();
        t_clean_traffic();
        t_fetch_faults();
        t_data_faults();
        t_mixed();
        drive(0, 0, 0, 0, 0, 1);
        expect_ret("R1 quiet", 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule